// File: doc/BRIEF.md
# GPIO Port with Per-Pin Edge Events

This block is a small register-mapped general-purpose I/O port. A build-time parameter fixes the direction of the whole port. An output port is a writable data register whose bits drive the pin vector. An input port brings the pins through a two-flop synchronizer and returns their level on read. It watches every pin for a programmable event: a rising edge, a falling edge, or any change of level.

Events latch into a pending register, and software clears that register by writing ones to it. An enable register masks the pending bits before they are reduced onto a single interrupt line. Every register is as wide as the pin count and is split into bus-width slices, one slice per 32-bit word address. Read data is registered, so it appears one clock after the address is presented.

Top module: `gpio_edge_port`

## Requirements
- R1: The IS_OUTPUT parameter fixes the port direction. An output port has a data register that drives `pins_out`, and its other registers read zero while `irq` stays 0. An input port ignores writes to its data register and holds `pins_out` at zero.
- R2: An input port's data register reads the pins through a two-flop synchronizer. A level applied before clock edge k is in the synchronized value after edge k+1, and it is returned on `csr_rdata` after edge k+2 when the data register is addressed.
- R3: Register bits at or above the pin count always read 0. A word address beyond the last register reads all zeros, and writes to it have no effect.
- R4: With the mode bit of a pin set to 1, any change of its synchronized level sets its pending bit.
- R5: With the mode bit 0, an edge-select bit of 0 arms the pin for rising edges only, and an edge-select bit of 1 arms it for falling edges only.
- R6: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: `irq` is high exactly when some pin has both its pending bit and its enable bit set. It follows register changes in the same cycle, with no extra delay.
- R8: If a pin's event and a clear-by-write of that pin reach the same clock edge, the pending bit ends set.
- R9: Pending bits latch even when their enable bit is 0. Setting the enable later raises `irq` for the earlier event.
- R10: After reset, the mode, edge-select, pending, enable and output data registers are zero, and so are `csr_rdata` and `irq`.
- R11: Register r, slice s lives at byte address 4*(r*S+s), where S is the number of slices per register and the two low address bits are ignored. Slice s carries bits [s*CSR_DW +: CSR_DW]. The register order is data (0), mode (1), edge-select (2), pending (3), enable (4).
- R12: A pin event becomes visible in the pending register, and therefore on `irq`, after clock edge k+2 for a level applied before edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_addr | input | ADDR_W | Byte address of the register slice |
| csr_we | input | 1 | Write strobe for the addressed slice |
| csr_wdata | input | CSR_DW | Write data for one slice |
| csr_rdata | output | CSR_DW | Registered read data for the slice addressed on the previous cycle |
| irq | output | 1 | OR of pending AND enable |
| pins_in | input | PIN_COUNT | Asynchronous pin levels (used only by an input port) |
| pins_out | output | PIN_COUNT | Driven pin levels (zero for an input port) |

## Verification
A pin event and a software clear of the same pending bit can reach one clock edge together. The bench provokes this by changing a pin that is set to any-change mode. It times a write-one-to-clear of that pin so that the write lands on the edge where the synchronized edge is registered. The pending bit must read back as set, both in a directed read and in the cycle-by-cycle reference model. The model is compared on every clock during a long phase of random pins and random register writes, so further collisions are judged the same way.

// File: rtl/gpio_edge_pkg.sv
// Package: shared register indices and size helpers for the GPIO edge port.
// Assumes the register order below is the order of the address map.
package gpio_edge_pkg;

    // Register index within the map; each register spans several slices.
    typedef enum logic [2:0] {
        REG_DATA = 3'd0,
        REG_MODE = 3'd1,
        REG_EDGE = 3'd2,
        REG_PEND = 3'd3,
        REG_EN   = 3'd4
    } gpio_reg_e;

    localparam int NUM_REGS = 5;

    // Number of bus-width slices needed to hold all pins.
    function automatic int slices_for(input int pins, input int dw);
        return (pins + dw - 1) / dw;
    endfunction

    // Width of an index that selects one of n slices (at least one bit).
    function automatic int index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gpio_edge_decode.sv
// Address decoder: splits a byte address into register index and slice,
// and expands the write data of one slice to a pin-wide mask and value.
// Assumes ADDR_W-2 >= 3 and word addresses are 4 bytes apart.
module gpio_edge_decode
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT = 12,
    parameter int CSR_DW    = 8,
    parameter int ADDR_W    = 6,
    localparam int SLICES   = slices_for(PIN_COUNT, CSR_DW),
    localparam int SLICE_W  = index_width(SLICES)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CSR_DW-1:0]    wdata,
    output logic                 hit_o,
    output gpio_reg_e            reg_o,
    output logic [SLICE_W-1:0]   slice_o,
    output logic [PIN_COUNT-1:0] wr_mask_o,
    output logic [PIN_COUNT-1:0] wr_bits_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int FULL_W = SLICES * CSR_DW;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] reg_num;
    logic [WORD_W-1:0] slice_num;
    logic [FULL_W-1:0] mask_full;
    logic [FULL_W-1:0] bits_full;
    logic              unused_bits;

    // Word index split into register number and slice number.
    always_comb begin
        word      = addr[ADDR_W-1:2];
        reg_num   = word / WORD_W'(SLICES);
        slice_num = word % WORD_W'(SLICES);
    end

    assign hit_o       = (reg_num < WORD_W'(NUM_REGS));
    assign reg_o       = gpio_reg_e'(reg_num[2:0]);
    assign slice_o     = slice_num[SLICE_W-1:0];
    assign unused_bits = ^{addr[1:0], reg_num, slice_num};

    // Move the slice's data and ones-mask to its bit position in the pin vector.
    always_comb begin
        mask_full = FULL_W'({CSR_DW{1'b1}}) << (int'(slice_o) * CSR_DW);
        bits_full = FULL_W'(wdata) << (int'(slice_o) * CSR_DW);
    end

    assign wr_mask_o = PIN_COUNT'(mask_full);
    assign wr_bits_o = PIN_COUNT'(bits_full);

endmodule

// File: rtl/gpio_edge_sync.sv
// Multi-flop synchronizer for asynchronous pin levels.
// Assumes STAGES >= 1; every stage resets to zero.
module gpio_edge_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Stage g: capture the previous stage (or the raw pins for stage 0).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (g == 0) begin
                stage_q[g] <= d;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_events.sv
// Event engine for an input port: holds mode, edge-select, pending and
// enable registers, detects per-pin edges on the synchronized levels and
// forms the interrupt. Assumes cur is already synchronous to clk.
module gpio_edge_events #(
    parameter int PIN_COUNT = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] cur,
    input  logic [PIN_COUNT-1:0] wr_mask,
    input  logic [PIN_COUNT-1:0] wr_bits,
    input  logic                 wr_mode,
    input  logic                 wr_edge,
    input  logic                 wr_pend,
    input  logic                 wr_en,
    output logic [PIN_COUNT-1:0] mode_o,
    output logic [PIN_COUNT-1:0] edge_o,
    output logic [PIN_COUNT-1:0] pend_o,
    output logic [PIN_COUNT-1:0] en_o,
    output logic                 irq_o
);
    logic [PIN_COUNT-1:0] prev_q;
    logic [PIN_COUNT-1:0] mode_q;
    logic [PIN_COUNT-1:0] edge_q;
    logic [PIN_COUNT-1:0] pend_q;
    logic [PIN_COUNT-1:0] en_q;
    logic [PIN_COUNT-1:0] rise;
    logic [PIN_COUNT-1:0] fall;
    logic [PIN_COUNT-1:0] ev;
    logic [PIN_COUNT-1:0] clr;

    // Previous synchronized level, for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    // Per-pin event select: any change, or the chosen single edge.
    always_comb begin
        rise = cur & ~prev_q;
        fall = ~cur & prev_q;
        for (int i = 0; i < PIN_COUNT; i++) begin
            if (mode_q[i])      ev[i] = rise[i] | fall[i];
            else if (edge_q[i]) ev[i] = fall[i];
            else                ev[i] = rise[i];
        end
    end

    // Bits to clear this cycle from a write-one-to-clear access.
    assign clr = wr_pend ? (wr_mask & wr_bits) : '0;

    // Configuration registers: masked update of the addressed slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            edge_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_mode) mode_q <= (mode_q & ~wr_mask) | (wr_bits & wr_mask);
            if (wr_edge) edge_q <= (edge_q & ~wr_mask) | (wr_bits & wr_mask);
            if (wr_en)   en_q   <= (en_q & ~wr_mask) | (wr_bits & wr_mask);
        end
    end

    // Pending register: a new event outranks a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | ev;
    end

    assign irq_o  = |(pend_q & en_q);
    assign mode_o = mode_q;
    assign edge_o = edge_q;
    assign pend_o = pend_q;
    assign en_o   = en_q;

    // R4
    ev_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((pend_q & $past(ev)) == $past(ev)));

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0));

    // R5
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ~mode_q & ~edge_q & ~cur) == '0));

    // R7
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !irq_o);

endmodule

// File: rtl/gpio_edge_port.sv
// Top of the GPIO edge port. IS_OUTPUT selects at build time between an
// output port (data register to pins) and an input port (synchronizer,
// edge events, interrupt). Read data is registered one cycle after the
// address. Assumes PIN_COUNT fits in the slices the map reserves.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int PIN_COUNT   = 12,
    parameter int CSR_DW      = 8,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit IS_OUTPUT   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    csr_addr,
    input  logic                 csr_we,
    input  logic [CSR_DW-1:0]    csr_wdata,
    output logic [CSR_DW-1:0]    csr_rdata,
    output logic                 irq,
    input  logic [PIN_COUNT-1:0] pins_in,
    output logic [PIN_COUNT-1:0] pins_out
);
    localparam int SLICES  = slices_for(PIN_COUNT, CSR_DW);
    localparam int SLICE_W = index_width(SLICES);
    localparam int FULL_W  = SLICES * CSR_DW;

    logic                 hit;
    gpio_reg_e            reg_sel;
    logic [SLICE_W-1:0]   slice_sel;
    logic [PIN_COUNT-1:0] wr_mask;
    logic [PIN_COUNT-1:0] wr_bits;
    logic [PIN_COUNT-1:0] rd_val;
    logic [FULL_W-1:0]    rd_full;
    logic [CSR_DW-1:0]    rd_next;

    gpio_edge_decode #(
        .PIN_COUNT (PIN_COUNT),
        .CSR_DW    (CSR_DW),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr      (csr_addr),
        .wdata     (csr_wdata),
        .hit_o     (hit),
        .reg_o     (reg_sel),
        .slice_o   (slice_sel),
        .wr_mask_o (wr_mask),
        .wr_bits_o (wr_bits)
    );

    if (IS_OUTPUT) begin : g_out
        logic [PIN_COUNT-1:0] dout_q;
        logic                 wr_data;
        logic [PIN_COUNT-1:0] unused_pins;

        assign wr_data     = csr_we && hit && (reg_sel == REG_DATA);
        assign unused_pins = pins_in;

        // Output data register: masked update of the addressed slice.
        always_ff @(posedge clk) begin
            if (!rst_n)       dout_q <= '0;
            else if (wr_data) dout_q <= (dout_q & ~wr_mask) | (wr_bits & wr_mask);
        end

        // Read source: only the data register exists in this variant.
        always_comb begin
            rd_val = (hit && reg_sel == REG_DATA) ? dout_q : '0;
        end

        assign pins_out = dout_q;
        assign irq      = 1'b0;

        // R1
        dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_data |=> $stable(pins_out));

    end else begin : g_in
        logic [PIN_COUNT-1:0] pins_sync;
        logic [PIN_COUNT-1:0] mode_v;
        logic [PIN_COUNT-1:0] edge_v;
        logic [PIN_COUNT-1:0] pend_v;
        logic [PIN_COUNT-1:0] en_v;
        logic                 wr_ok;

        assign wr_ok = csr_we && hit;

        gpio_edge_sync #(
            .WIDTH  (PIN_COUNT),
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pins_in),
            .q     (pins_sync)
        );

        gpio_edge_events #(
            .PIN_COUNT (PIN_COUNT)
        ) u_events (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur     (pins_sync),
            .wr_mask (wr_mask),
            .wr_bits (wr_bits),
            .wr_mode (wr_ok && reg_sel == REG_MODE),
            .wr_edge (wr_ok && reg_sel == REG_EDGE),
            .wr_pend (wr_ok && reg_sel == REG_PEND),
            .wr_en   (wr_ok && reg_sel == REG_EN),
            .mode_o  (mode_v),
            .edge_o  (edge_v),
            .pend_o  (pend_v),
            .en_o    (en_v),
            .irq_o   (irq)
        );

        // Read source selection among the five input-port registers.
        always_comb begin
            rd_val = '0;
            if (hit) begin
                case (reg_sel)
                    REG_DATA: rd_val = pins_sync;
                    REG_MODE: rd_val = mode_v;
                    REG_EDGE: rd_val = edge_v;
                    REG_PEND: rd_val = pend_v;
                    REG_EN:   rd_val = en_v;
                    default:  rd_val = '0;
                endcase
            end
        end

        assign pins_out = '0;
    end

    // Pick the addressed slice out of the zero-extended register value.
    always_comb begin
        rd_full = FULL_W'(rd_val) >> (int'(slice_sel) * CSR_DW);
        rd_next = CSR_DW'(rd_full);
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) csr_rdata <= '0;
        else        csr_rdata <= rd_next;
    end

    // R10
    rdata_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (csr_rdata == '0));

endmodule

// File: tb/sim_gpio_edge_port.sv
// Bench: an input instance (u0) and an output instance (u1) share one bus.
// A behavioural reference model runs beside them and is compared on every
// clock; directed sequences add checks with hand-computed values.
module sim_gpio_edge_port;
    localparam int NP   = 12;
    localparam int DW   = 8;
    localparam int AW   = 6;
    localparam int SUBS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [NP-1:0] pins = '0;
    logic [DW-1:0] rdata0, rdata1;
    logic          irq0, irq1;
    logic [NP-1:0] pout0, pout1;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_port #(.PIN_COUNT(NP), .CSR_DW(DW), .ADDR_W(AW), .IS_OUTPUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rdata0), .irq(irq0), .pins_in(pins), .pins_out(pout0));

    gpio_edge_port #(.PIN_COUNT(NP), .CSR_DW(DW), .ADDR_W(AW), .IS_OUTPUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rdata1), .irq(irq1), .pins_in(pins), .pins_out(pout1));

    // Reference model state.
    logic [NP-1:0] m_s1, m_s2, m_prev, m_mode, m_edge, m_pend, m_en, m_dout;
    logic [DW-1:0] m_rd0, m_rd1;
    string         m_tag0 = "R10";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mdl_read(input bit outp, input int a);
        int w, r, s;
        logic [NP-1:0] v;
        w = a / 4; r = w / SUBS; s = w % SUBS;
        v = '0;
        if (outp) begin
            if (r == 0) v = m_dout;
        end else begin
            case (r)
                0: v = m_s2;
                1: v = m_mode;
                2: v = m_edge;
                3: v = m_pend;
                4: v = m_en;
                default: v = '0;
            endcase
        end
        return DW'(32'(v) >> (s * DW));
    endfunction

    // Model step at each clock edge, using values from before the edge.
    always @(posedge clk) begin
        int w, r, s;
        logic [NP-1:0] ev, msk, bts;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_mode = '0; m_edge = '0;
            m_pend = '0; m_en = '0; m_dout = '0; m_rd0 = '0; m_rd1 = '0;
        end else begin
            w = int'(addr) / 4; r = w / SUBS; s = w % SUBS;
            m_rd0 = mdl_read(1'b0, int'(addr));
            m_rd1 = mdl_read(1'b1, int'(addr));
            case (r)
                0: m_tag0 = "R2";
                1, 2, 4: m_tag0 = "R11";
                3: m_tag0 = "R12";
                default: m_tag0 = "R3";
            endcase
            for (int i = 0; i < NP; i++) begin
                if (m_mode[i])      ev[i] = m_s2[i] != m_prev[i];
                else if (m_edge[i]) ev[i] = !m_s2[i] && m_prev[i];
                else                ev[i] = m_s2[i] && !m_prev[i];
                msk[i] = (i / DW) == s;
                bts[i] = wdata[i % DW];
            end
            if (we && r == 0) m_dout = (m_dout & ~msk) | (bts & msk);
            if (we && r == 1) m_mode = (m_mode & ~msk) | (bts & msk);
            if (we && r == 2) m_edge = (m_edge & ~msk) | (bts & msk);
            if (we && r == 4) m_en   = (m_en & ~msk) | (bts & msk);
            if (we && r == 3) m_pend = m_pend & ~(bts & msk);
            m_pend = m_pend | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            check(m_tag0, 32'(rdata0), 32'(m_rd0));
            check("R7", 32'(irq0), 32'(|(m_pend & m_en)));
            check("R1", 32'(pout0), 32'(0));
            check("R1", 32'(rdata1), 32'(m_rd1));
            check("R1", 32'(pout1), 32'(m_dout));
            check("R1", 32'(irq1), 32'(0));
        end
    end

    task automatic wr(input int a, input logic [DW-1:0] d);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input bit outp, input int a, input logic [DW-1:0] exp, input string tag);
        addr = AW'(a); we = 1'b0;
        @(negedge clk);
        check(tag, 32'(outp ? rdata1 : rdata0), 32'(exp));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R10: everything reads zero after reset
        check("R10", 32'(irq0), 32'(0));
        check("R10", 32'(pout1), 32'(0));
        rd(1'b0, 8, 8'h00, "R10");
        rd(1'b0, 16, 8'h00, "R10");
        rd(1'b0, 24, 8'h00, "R10");
        rd(1'b0, 32, 8'h00, "R10");
        rd(1'b0, 0, 8'h00, "R10");
        // Pin 1 falling, pin 2 any change, others rising.
        wr(8, 8'h04);
        wr(16, 8'h02);
        rd(1'b0, 8, 8'h04, "R11");
        // R5 and R4: rising on pins 0..2
        pins = 12'h007; settle();
        rd(1'b0, 24, 8'h05, "R5");
        check("R9", 32'(irq0), 32'(0));
        wr(32, 8'h01);
        check("R9", 32'(irq0), 32'(1));
        // R4 and R5: falling on pins 0..2
        pins = 12'h000; settle();
        rd(1'b0, 24, 8'h07, "R4");
        // R6: clear only bits written as 1
        wr(24, 8'h02);
        rd(1'b0, 24, 8'h05, "R6");
        wr(24, 8'h00);
        rd(1'b0, 24, 8'h05, "R6");
        wr(24, 8'hFF);
        rd(1'b0, 24, 8'h00, "R6");
        check("R7", 32'(irq0), 32'(0));
        // R8: event on pin 2 lands on the same edge as its clear
        pins = 12'h004;
        @(negedge clk);
        @(negedge clk);
        wr(24, 8'h04);
        rd(1'b0, 24, 8'h04, "R8");
        pins = 12'h000; settle();
        wr(24, 8'hFF);
        // R12: pending visible after the second edge following the pin change
        pins = 12'h001;
        @(negedge clk);
        @(negedge clk);
        check("R12", 32'(irq0), 32'(0));
        @(negedge clk);
        check("R12", 32'(irq0), 32'(1));
        wr(24, 8'h01);
        // R2 and R11: upper slice of pins
        pins = 12'hF00; settle();
        rd(1'b0, 4, 8'h0F, "R2");
        rd(1'b0, 28, 8'h0F, "R11");
        // R3: bits above the pin count read zero, unmapped address reads zero
        wr(12, 8'hFF);
        rd(1'b0, 12, 8'h0F, "R3");
        rd(1'b0, 40, 8'h00, "R3");
        wr(40, 8'hFF);
        rd(1'b0, 40, 8'h00, "R3");
        // R1: output port data, input port ignores data writes
        wr(0, 8'hA5);
        check("R1", 32'(pout1), 32'h0A5);
        rd(1'b0, 0, 8'h00, "R1");
        wr(4, 8'hFF);
        check("R1", 32'(pout1), 32'hFA5);
        rd(1'b1, 4, 8'h0F, "R1");
        rd(1'b1, 8, 8'h00, "R1");
        // Random phase, judged by the per-clock model comparison.
        for (int n = 0; n < 3000; n++) begin
            pins = NP'($urandom);
            addr = AW'(4 * ($urandom % 11));
            wdata = DW'($urandom);
            we = ($urandom % 3) == 0;
            @(negedge clk);
        end
        we = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule